// File: doc/BRIEF.md
# Cycle Status Vector Accumulator

This block collects per-node status flags that arrive inside received frames during one communication cycle and gives the host a steady copy of them. Each bit of the status vector belongs to exactly one node. Whenever a valid vector is received, it is merged into an internal working register by bitwise OR. A set bit therefore means that its owning node reported the condition at least once during the cycle.

A cycle-end strobe closes the cycle. On that strobe the working register, together with any vector arriving in the same clock, is copied into a host-visible register. The working register then starts the next cycle from zero. The host copy is double buffered and nothing on the host side can hold or delay it. The host must finish reading one snapshot before the next cycle end replaces it. A build option adds a one-clock pulse that marks each snapshot update.

Top module: `nodestat_accum`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the host view, the update pulse and the working register. A cycle end after reset with no receptions publishes all zeros.
- R2: Every received vector (`rx_valid` high) is combined with the earlier ones of the same cycle by bitwise OR. A later vector never overwrites an earlier one.
- R3: `rx_vec` has no effect while `rx_valid` is low.
- R4: On the clock after `cyc_end` is high, `host_vec` shows the OR of all vectors received in the cycle that just closed.
- R5: The working register starts empty after every cycle end. A cycle with no receptions publishes zero, and bits from an earlier cycle never appear in a later snapshot.
- R6: A vector received in the same clock as `cyc_end` belongs to the closing cycle's snapshot and is not carried into the next cycle.
- R7: `host_vec` changes only on the clock after a cycle end (or a reset). Between cycle ends it stays constant whatever arrives on the receive side.
- R8: With `PULSE_MODE = SNAP_PULSE_ON`, `snap_upd` is high for exactly the one clock after each `cyc_end` and is low at all other times. With `SNAP_PULSE_OFF` it is always low.
- R9: Cycle ends on consecutive clocks each publish their own snapshot, holding only the vectors received in their own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_end | input | 1 | Cycle boundary strobe, one clock |
| rx_valid | input | 1 | Qualifies `rx_vec` for this clock |
| rx_vec | input | VEC_W | Received status vector, one bit per node |
| host_vec | output | VEC_W | Snapshot of the previous complete cycle |
| snap_upd | output | 1 | One-clock pulse when `host_vec` is reloaded (optional) |

## Verification
The bench goes after the ways this block can misplace a vector in time. A vector that lands together with `cyc_end` must show up in the closing snapshot and never in the next one. A design that dropped it, or cleared before merging, would publish a short snapshot or a stale bit one cycle late. Consecutive cycle ends and empty cycles show whether the working register is truly cleared: a design that forgot to clear would let bits leak forward. A design that overwrote instead of ORing would lose earlier nodes' bits. Receive traffic with `rx_valid` low, and idle stretches between boundaries, expose a host view that moves mid-cycle or picks up unqualified data. A mid-cycle reset shows whether partial accumulations survive.

// File: rtl/nodestat_pkg.sv
package nodestat_pkg;

   // Selects whether the top module builds the snapshot-updated pulse.
   typedef enum logic [0:0] {
      SNAP_PULSE_OFF = 1'b0,
      SNAP_PULSE_ON  = 1'b1
   } snap_pulse_e;

   localparam int unsigned NODESTAT_MAX_W = 1024;

endpackage

// File: rtl/nodestat_merge.sv
// Working register: one lane per node bit, OR-accumulated over a cycle.
module nodestat_merge #(
   parameter int unsigned VEC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cyc_end,
   input  logic             rx_valid,
   input  logic [VEC_W-1:0] rx_vec,
   output logic [VEC_W-1:0] merged
);

   logic [VEC_W-1:0] acc_q;
   logic [VEC_W-1:0] rx_gated;

   assign rx_gated = rx_vec & {VEC_W{rx_valid}};

   for (genvar b = 0; b < VEC_W; b++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst)
            acc_q[b] <= 1'b0;
         else if (cyc_end)
            acc_q[b] <= 1'b0;
         else if (rx_gated[b])
            acc_q[b] <= 1'b1;
      end
   end

   // Value presented for publication includes a same-clock reception.
   assign merged = acc_q | rx_gated;

   AST_MERGE_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
      (!cyc_end) |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R2

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
      (!cyc_end && !rx_valid) |=> $stable(acc_q)); // R3

   AST_CLEARED_AFTER_END: assert property (@(posedge clk) disable iff (rst)
      cyc_end |=> (acc_q == '0)); // R5

endmodule

// File: rtl/nodestat_snap.sv
// Host-visible display register, loaded only at a cycle boundary.
module nodestat_snap #(
   parameter int unsigned VEC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [VEC_W-1:0] din,
   output logic [VEC_W-1:0] dout
);

   logic [VEC_W-1:0] disp_q;

   always_ff @(posedge clk) begin
      if (rst)
         disp_q <= '0;
      else if (load)
         disp_q <= din;
   end

   assign dout = disp_q;

   AST_DISP_HELD: assert property (@(posedge clk) disable iff (rst)
      (!load) |=> $stable(disp_q)); // R7

endmodule

// File: rtl/nodestat_pulse.sv
// Optional snapshot-updated strobe; the variant is picked at elaboration.
module nodestat_pulse
   import nodestat_pkg::*;
#(
   parameter snap_pulse_e PULSE_MODE = SNAP_PULSE_ON
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic pulse
);

   if (PULSE_MODE == SNAP_PULSE_ON) begin : g_on
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (rst)
            pulse_q <= 1'b0;
         else
            pulse_q <= fire;
      end
      assign pulse = pulse_q;

      AST_PULSE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
         fire |=> pulse); // R8
      AST_PULSE_ONLY_AFTER_END: assert property (@(posedge clk) disable iff (rst)
         (!fire) |=> (!pulse)); // R8
   end else begin : g_off
      assign pulse = 1'b0;
      logic unused_in;
      assign unused_in = &{1'b0, clk, rst, fire};
   end

endmodule

// File: rtl/nodestat_accum.sv
module nodestat_accum
   import nodestat_pkg::*;
#(
   parameter int unsigned VEC_W      = 16,
   parameter snap_pulse_e PULSE_MODE = SNAP_PULSE_ON
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cyc_end,
   input  logic             rx_valid,
   input  logic [VEC_W-1:0] rx_vec,
   output logic [VEC_W-1:0] host_vec,
   output logic             snap_upd
);

   if (VEC_W < 1 || VEC_W > NODESTAT_MAX_W) begin : g_bad_width
      $error("nodestat_accum: VEC_W out of range");
   end

   logic [VEC_W-1:0] merged;

   nodestat_merge #(.VEC_W(VEC_W)) u_merge (
      .clk      (clk),
      .rst      (rst),
      .cyc_end  (cyc_end),
      .rx_valid (rx_valid),
      .rx_vec   (rx_vec),
      .merged   (merged)
   );

   nodestat_snap #(.VEC_W(VEC_W)) u_snap (
      .clk  (clk),
      .rst  (rst),
      .load (cyc_end),
      .din  (merged),
      .dout (host_vec)
   );

   nodestat_pulse #(.PULSE_MODE(PULSE_MODE)) u_pulse (
      .clk   (clk),
      .rst   (rst),
      .fire  (cyc_end),
      .pulse (snap_upd)
   );

   AST_SAME_CLOCK_RX_PUBLISHED: assert property (@(posedge clk) disable iff (rst)
      (cyc_end && rx_valid) |=> ((host_vec & $past(rx_vec)) == $past(rx_vec))); // R6

   AST_EMPTY_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
      (cyc_end && !rx_valid && $past(cyc_end) && !$past(rst)) |=> (host_vec == '0)); // R9

endmodule

// File: tb/nodestat_accum_test.sv
module nodestat_accum_test;
   import nodestat_pkg::*;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst;
   logic         cyc_end;
   logic         rx_valid;
   logic [W-1:0] rx_vec;
   logic [W-1:0] host_vec;
   logic         snap_upd;
   logic [W-1:0] host_vec_np;
   logic         snap_upd_np;

   int tests_run = 0;
   int tests_failed = 0;
   bit finished = 0;

   // Behavioural reference state
   logic [W-1:0] m_acc;
   logic [W-1:0] m_disp;
   logic         m_pulse;
   logic [W-1:0] history[$];

   always #10 clk = ~clk;

   nodestat_accum #(.VEC_W(W), .PULSE_MODE(SNAP_PULSE_ON)) uut (
      .clk(clk), .rst(rst), .cyc_end(cyc_end), .rx_valid(rx_valid),
      .rx_vec(rx_vec), .host_vec(host_vec), .snap_upd(snap_upd)
   );

   nodestat_accum #(.VEC_W(W), .PULSE_MODE(SNAP_PULSE_OFF)) uut_nopulse (
      .clk(clk), .rst(rst), .cyc_end(cyc_end), .rx_valid(rx_valid),
      .rx_vec(rx_vec), .host_vec(host_vec_np), .snap_upd(snap_upd_np)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_failed++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one clock from a negedge, update the model at the posedge,
   // then compare every output at the following negedge.
   task automatic tick(input logic r, input logic v, input logic [W-1:0] d,
                       input logic ce, input string req);
      rst = r; rx_valid = v; rx_vec = d; cyc_end = ce;
      @(posedge clk);
      if (r) begin
         m_acc = '0; m_disp = '0; m_pulse = 1'b0;
      end else begin
         m_pulse = ce;
         if (ce) begin
            m_disp = m_acc | (v ? d : '0);
            history.push_back(m_disp);
            m_acc = '0;
         end else if (v) begin
            m_acc = m_acc | d;
         end
      end
      @(negedge clk);
      check(req, host_vec, m_disp);
      check({req, " pulse"}, {{(W-1){1'b0}}, snap_upd}, {{(W-1){1'b0}}, m_pulse});
      check("R8 off-variant pulse", {{(W-1){1'b0}}, snap_upd_np}, '0);
      check({req, " off-variant view"}, host_vec_np, m_disp);
   endtask

   initial begin
      #(20 * 5000);
      if (!finished) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; cyc_end = 1'b0; rx_valid = 1'b0; rx_vec = '0;
      m_acc = '0; m_disp = '0; m_pulse = 1'b0;
      @(negedge clk);
      tick(1, 1, 16'hFFFF, 1, "R1 reset");
      tick(1, 0, 16'h0000, 0, "R1 reset");
      check("R1 reset view", host_vec, 16'h0000);

      // R2/R3/R4: OR merge, unqualified data ignored
      tick(0, 1, 16'h0001, 0, "R2 rx");
      tick(0, 1, 16'h0010, 0, "R2 rx");
      tick(0, 0, 16'hFFFF, 0, "R3 idle data");
      tick(0, 1, 16'h0001, 0, "R2 repeat bit");
      tick(0, 0, 16'hF0F0, 1, "R4 publish");
      check("R4 snapshot OR", host_vec, 16'h0011);
      check("R8 pulse high", {15'b0, snap_upd}, 16'h0001);
      tick(0, 0, 16'h0000, 0, "R8 pulse drop");
      check("R8 pulse one clock", {15'b0, snap_upd}, 16'h0000);

      // R5: empty cycle publishes zero
      tick(0, 0, 16'h1234, 0, "R5 idle");
      tick(0, 0, 16'h0000, 1, "R5 empty publish");
      check("R5 empty cycle", host_vec, 16'h0000);

      // R6: coincident reception
      tick(0, 1, 16'h0100, 0, "R6 rx");
      tick(0, 1, 16'h8000, 1, "R6 coincident");
      check("R6 coincident included", host_vec, 16'h8100);
      tick(0, 0, 16'h0000, 1, "R6 next cycle");
      check("R6 not carried", host_vec, 16'h0000);

      // R9: consecutive cycle ends
      tick(0, 1, 16'h0002, 1, "R9 b2b");
      check("R9 first", host_vec, 16'h0002);
      tick(0, 1, 16'h0004, 1, "R9 b2b");
      check("R9 second", host_vec, 16'h0004);
      tick(0, 0, 16'h0000, 1, "R9 b2b empty");
      check("R9 third empty", host_vec, 16'h0000);

      // R7: host view stable while receptions continue
      tick(0, 1, 16'h00A0, 1, "R7 load");
      for (int i = 0; i < 8; i++) begin
         tick(0, (i % 2) == 0, 16'h0101 << i, 0, "R7 hold");
         check("R7 held", host_vec, 16'h00A0);
      end
      tick(0, 0, 16'h0000, 1, "R7 publish");
      check("R7 next snapshot", host_vec, 16'h5555 & 16'h1515 | 16'h0000 | 16'h0101 | 16'h0404 | 16'h1010 | 16'h4040);

      // Patterned cycles compared against the model
      for (int c = 0; c < 20; c++) begin
         for (int k = 0; k < 5; k++)
            tick(0, ((c + k) % 3) != 0, 16'(1 << ((c * 7 + k * 3) % W)), 0, "R2 pattern");
         tick(0, (c % 2) == 1, 16'(1 << (c % W)), 1, "R4 pattern publish");
      end

      // R1: mid-cycle reset discards the partial accumulation
      tick(0, 1, 16'h00FF, 0, "R1 pre-reset rx");
      tick(1, 0, 16'h0000, 0, "R1 mid reset");
      tick(0, 0, 16'h0000, 1, "R1 post-reset publish");
      check("R1 partial discarded", host_vec, 16'h0000);

      check("R4 snapshots recorded", 16'(history.size()), 16'd30);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

endmodule